// File: doc/BRIEF.md
# Pipeline Hazard Controller: Load-Use Interlock, Branch Squash and Halt Detect

This block holds the control decisions for a five-stage in-order core that predicts every branch not taken. Each cycle it looks at the control fields of the instructions in the decode, execute, memory and write-back stage registers. From these it decides three things. It stalls fetch and decode for a single cycle when an instruction depends on a load that has not yet returned its data. It steers the program counter to a branch target when an equality branch, resolved in the memory stage, turns out to be taken. It raises a halt once a halt instruction reaches the last pipeline register.

The datapath uses the outputs as follows. `stall_o` holds the PC and the fetch/decode register. Each `kill_*` output makes its register load the noop word 0x1c00000 in place of the incoming instruction. A bubble during a stall is a kill of the decode/execute register. The block also chooses and forms the next PC value. A taken branch discards the three younger instructions already in flight, and it wins over any stall raised in the same cycle.

The block works on decoded control fields, not whole instruction words. For the decode-stage instruction the port `ifid_ctl` carries instruction bits 24..16 packed as: [8:6] opcode, [5:3] first source register, [2:0] second source register (a load's destination). Opcode values are: add 0, nor 1, lw 2, sw 3, beq 4, 5 unused, halt 6, noop 7.

Top module: `hzc_ctl`

## Requirements
- R1: After reset, with noop (7) in every stage and PC 0, the block gives no stall, no kills, PC select 0 (sequential), next PC 1 and halt low.
- R2: The block raises a load-use interlock only when the execute-stage opcode is lw (2) and the decode-stage instruction reads the register named by `idex_dst`.
- R3: The decode-stage instruction reads its first source ([5:3]) when its opcode is add, nor, lw, sw or beq. It reads its second source ([2:0]) when its opcode is add, nor, sw or beq. halt, noop and opcode 5 read nothing.
- R4: During an interlock with no taken branch, `stall_o` and `kill_idex_o` are 1, `kill_ifid_o` and `kill_exmem_o` are 0, PC select is 1 (hold) and next PC equals `pc_i`.
- R5: With no interlock and no taken branch, no kill is raised, PC select is 0 and next PC is `pc_i`+1, wrapping at the PC width.
- R6: A beq (4) in the memory stage with `br_eq_i` high is taken. It raises all three kills, sets PC select to 2 (redirect) and makes next PC equal `br_target_i`.
- R7: A beq with `br_eq_i` low, or any other memory-stage opcode, causes no redirect and no squash.
- R8: A taken branch overrides an interlock raised in the same cycle. `stall_o` is 0 and the redirect outputs of R6 apply.
- R9: `halt_o` rises in the same cycle that the write-back-stage opcode is halt (6). It stays high until reset. A halt opcode in any earlier stage does not raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ifid_ctl | input | 9 | Decode-stage opcode and two source register fields |
| idex_op | input | 3 | Execute-stage opcode |
| idex_dst | input | 3 | Execute-stage register written by a load |
| exmem_op | input | 3 | Memory-stage opcode |
| memwb_op | input | 3 | Write-back-stage opcode |
| br_eq_i | input | 1 | Branch operands compared equal (memory stage) |
| br_target_i | input | PC_W | Resolved branch target carried in EX/MEM |
| pc_i | input | PC_W | Current PC |
| next_pc_o | output | PC_W | PC value to load at the next edge |
| pc_sel_o | output | 2 | 0 sequential, 1 hold, 2 redirect |
| stall_o | output | 1 | Freeze PC and fetch/decode register |
| kill_ifid_o | output | 1 | Load noop into fetch/decode register |
| kill_idex_o | output | 1 | Load noop into decode/execute register |
| kill_exmem_o | output | 1 | Load noop into execute/memory register |
| halt_o | output | 1 | Machine halted |

## Verification
The assertions check on every cycle that a stall occurs only behind a load and always has the hold/bubble form. They also check that a taken branch squashes all three registers and suppresses the stall, that the PC is sequential when nothing intervenes, and that halt, once raised, stays high. Only the bench's sweep can show that the interlock fires for exactly the right pairings of consumer opcode, source fields and load destination, with no spurious stall. The same holds for a halt opcode in an earlier stage leaving `halt_o` low, and for the full priority between simultaneous redirect and interlock across every memory-stage opcode.

// File: rtl/hzc_pkg.sv
package hzc_pkg;

    localparam int OP_W   = 3;
    localparam int REG_W  = 3;
    localparam int NSRC   = 2;
    localparam int CTL_W  = OP_W + NSRC * REG_W;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 3'd0,
        OP_NOR  = 3'd1,
        OP_LW   = 3'd2,
        OP_SW   = 3'd3,
        OP_BEQ  = 3'd4,
        OP_RSV  = 3'd5,
        OP_HALT = 3'd6,
        OP_NOOP = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        PCS_SEQ      = 2'd0,
        PCS_HOLD     = 2'd1,
        PCS_REDIRECT = 2'd2
    } pcsel_e;

    // Source operands of a consumer: index 0 is the first field, 1 the second.
    typedef struct packed {
        logic [NSRC-1:0]            used;
        logic [NSRC-1:0][REG_W-1:0] src;
    } srcs_t;

    function automatic logic reads_first(op_e op);
        case (op)
            OP_ADD, OP_NOR, OP_LW, OP_SW, OP_BEQ: return 1'b1;
            default:                              return 1'b0;
        endcase
    endfunction

    function automatic logic reads_second(op_e op);
        case (op)
            OP_ADD, OP_NOR, OP_SW, OP_BEQ: return 1'b1;
            default:                       return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/hzc_decode.sv
module hzc_decode
    import hzc_pkg::*;
(
    input  logic [CTL_W-1:0] ctl_i,
    output srcs_t            srcs_o
);
    op_e op;

    always_comb begin
        op = op_e'(ctl_i[CTL_W-1 -: OP_W]);
        srcs_o.used[0] = reads_first(op);
        srcs_o.used[1] = reads_second(op);
        srcs_o.src[0]  = ctl_i[2*REG_W-1 -: REG_W];
        srcs_o.src[1]  = ctl_i[REG_W-1:0];
    end
endmodule

// File: rtl/hzc_loaduse.sv
module hzc_loaduse
    import hzc_pkg::*;
(
    input  logic [OP_W-1:0]  prod_op,
    input  logic [REG_W-1:0] prod_dst,
    input  srcs_t            cons,
    output logic             lu_req
);
    logic [NSRC-1:0] hit;

    for (genvar k = 0; k < NSRC; k++) begin : g_src
        assign hit[k] = cons.used[k] && (cons.src[k] == prod_dst);
    end

    assign lu_req = (op_e'(prod_op) == OP_LW) && (|hit);
endmodule

// File: rtl/hzc_redirect.sv
module hzc_redirect
    import hzc_pkg::*;
#(
    parameter int PC_W = 16
) (
    input  logic [OP_W-1:0] exmem_op,
    input  logic            br_eq_i,
    input  logic            lu_req,
    input  logic [PC_W-1:0] pc_i,
    input  logic [PC_W-1:0] tgt_i,
    output logic [PC_W-1:0] next_pc_o,
    output pcsel_e          sel_o,
    output logic            stall_o,
    output logic            kill_ifid_o,
    output logic            kill_idex_o,
    output logic            kill_exmem_o
);
    logic taken;

    always_comb begin
        taken        = (op_e'(exmem_op) == OP_BEQ) && br_eq_i;
        stall_o      = lu_req && !taken;
        kill_ifid_o  = taken;
        kill_idex_o  = taken || lu_req;
        kill_exmem_o = taken;
        if (taken) begin
            sel_o     = PCS_REDIRECT;
            next_pc_o = tgt_i;
        end else if (lu_req) begin
            sel_o     = PCS_HOLD;
            next_pc_o = pc_i;
        end else begin
            sel_o     = PCS_SEQ;
            next_pc_o = pc_i + PC_W'(1);
        end
    end
endmodule

// File: rtl/hzc_halt.sv
module hzc_halt
    import hzc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [OP_W-1:0] memwb_op,
    output logic            halt_o
);
    logic seen_q;
    logic at_end;

    assign at_end = (op_e'(memwb_op) == OP_HALT);

    always_ff @(posedge clk) begin
        if (rst)         seen_q <= 1'b0;
        else if (at_end) seen_q <= 1'b1;
    end

    assign halt_o = seen_q || at_end;
endmodule

// File: rtl/hzc_ctl.sv
module hzc_ctl
    import hzc_pkg::*;
#(
    parameter int PC_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CTL_W-1:0] ifid_ctl,
    input  logic [OP_W-1:0]  idex_op,
    input  logic [REG_W-1:0] idex_dst,
    input  logic [OP_W-1:0]  exmem_op,
    input  logic [OP_W-1:0]  memwb_op,
    input  logic             br_eq_i,
    input  logic [PC_W-1:0]  br_target_i,
    input  logic [PC_W-1:0]  pc_i,
    output logic [PC_W-1:0]  next_pc_o,
    output logic [1:0]       pc_sel_o,
    output logic             stall_o,
    output logic             kill_ifid_o,
    output logic             kill_idex_o,
    output logic             kill_exmem_o,
    output logic             halt_o
);
    srcs_t  cons;
    logic   lu_req;
    pcsel_e sel;

    hzc_decode u_dec (
        .ctl_i  (ifid_ctl),
        .srcs_o (cons)
    );

    hzc_loaduse u_lu (
        .prod_op  (idex_op),
        .prod_dst (idex_dst),
        .cons     (cons),
        .lu_req   (lu_req)
    );

    hzc_redirect #(.PC_W(PC_W)) u_rd (
        .exmem_op     (exmem_op),
        .br_eq_i      (br_eq_i),
        .lu_req       (lu_req),
        .pc_i         (pc_i),
        .tgt_i        (br_target_i),
        .next_pc_o    (next_pc_o),
        .sel_o        (sel),
        .stall_o      (stall_o),
        .kill_ifid_o  (kill_ifid_o),
        .kill_idex_o  (kill_idex_o),
        .kill_exmem_o (kill_exmem_o)
    );

    assign pc_sel_o = sel;

    hzc_halt u_halt (
        .clk      (clk),
        .rst      (rst),
        .memwb_op (memwb_op),
        .halt_o   (halt_o)
    );
endmodule

// File: rtl/hzc_ctl_chk.sv
module hzc_ctl_chk
    import hzc_pkg::*;
#(
    parameter int PC_W = 16
) (
    input logic            clk,
    input logic            rst,
    input logic [OP_W-1:0] idex_op,
    input logic [OP_W-1:0] exmem_op,
    input logic [OP_W-1:0] memwb_op,
    input logic            br_eq_i,
    input logic [PC_W-1:0] br_target_i,
    input logic [PC_W-1:0] pc_i,
    input logic [PC_W-1:0] next_pc_o,
    input logic [1:0]      pc_sel_o,
    input logic            stall_o,
    input logic            kill_ifid_o,
    input logic            kill_idex_o,
    input logic            kill_exmem_o,
    input logic            halt_o
);
    logic br_taken;
    assign br_taken = (exmem_op == 3'd4) && br_eq_i;

    assert_stall_needs_load_R2: assert property (@(posedge clk) disable iff (rst)
        stall_o |-> (idex_op == 3'd2));

    assert_stall_shape_R4: assert property (@(posedge clk) disable iff (rst)
        stall_o |-> (kill_idex_o && !kill_ifid_o && !kill_exmem_o
                     && pc_sel_o == 2'd1 && next_pc_o == pc_i));

    assert_seq_pc_R5: assert property (@(posedge clk) disable iff (rst)
        (pc_sel_o == 2'd0) |-> (next_pc_o == PC_W'(pc_i + PC_W'(1))
                                && !kill_ifid_o && !kill_idex_o && !kill_exmem_o));

    assert_taken_squash_R6: assert property (@(posedge clk) disable iff (rst)
        br_taken |-> (kill_ifid_o && kill_idex_o && kill_exmem_o
                      && pc_sel_o == 2'd2 && next_pc_o == br_target_i));

    assert_no_squash_R7: assert property (@(posedge clk) disable iff (rst)
        !br_taken |-> (!kill_ifid_o && !kill_exmem_o && pc_sel_o != 2'd2));

    assert_redirect_wins_R8: assert property (@(posedge clk) disable iff (rst)
        br_taken |-> !stall_o);

    assert_halt_seen_R9: assert property (@(posedge clk) disable iff (rst)
        (memwb_op == 3'd6) |-> halt_o);

    assert_halt_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(halt_o)) |-> halt_o);
endmodule

bind hzc_ctl hzc_ctl_chk #(.PC_W(PC_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .idex_op      (idex_op),
    .exmem_op     (exmem_op),
    .memwb_op     (memwb_op),
    .br_eq_i      (br_eq_i),
    .br_target_i  (br_target_i),
    .pc_i         (pc_i),
    .next_pc_o    (next_pc_o),
    .pc_sel_o     (pc_sel_o),
    .stall_o      (stall_o),
    .kill_ifid_o  (kill_ifid_o),
    .kill_idex_o  (kill_idex_o),
    .kill_exmem_o (kill_exmem_o),
    .halt_o       (halt_o)
);

// File: tb/sim_hzc_ctl.sv
module sim_hzc_ctl;
    localparam int PC_W = 16;
    localparam int WATCHDOG = 150000;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [8:0]      ifid_ctl = 9'h1c0;
    logic [2:0]      idex_op = 3'd7, idex_dst = 3'd0, exmem_op = 3'd7, memwb_op = 3'd7;
    logic            br_eq_i = 1'b0;
    logic [PC_W-1:0] br_target_i = '0, pc_i = '0;
    logic [PC_W-1:0] next_pc_o;
    logic [1:0]      pc_sel_o;
    logic            stall_o, kill_ifid_o, kill_idex_o, kill_exmem_o, halt_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    hzc_ctl #(.PC_W(PC_W)) u0 (
        .clk(clk), .rst(rst), .ifid_ctl(ifid_ctl), .idex_op(idex_op),
        .idex_dst(idex_dst), .exmem_op(exmem_op), .memwb_op(memwb_op),
        .br_eq_i(br_eq_i), .br_target_i(br_target_i), .pc_i(pc_i),
        .next_pc_o(next_pc_o), .pc_sel_o(pc_sel_o), .stall_o(stall_o),
        .kill_ifid_o(kill_ifid_o), .kill_idex_o(kill_idex_o),
        .kill_exmem_o(kill_exmem_o), .halt_o(halt_o)
    );

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit uses_first(int op);
        return (op <= 4);
    endfunction

    function automatic bit uses_second(int op);
        return (op == 0) || (op == 1) || (op == 3) || (op == 4);
    endfunction

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #2;
        // R1: quiet state after reset
        chk("R1", "stall", stall_o, 0);
        chk("R1", "kill_ifid", kill_ifid_o, 0);
        chk("R1", "kill_idex", kill_idex_o, 0);
        chk("R1", "kill_exmem", kill_exmem_o, 0);
        chk("R1", "pc_sel", pc_sel_o, 0);
        chk("R1", "next_pc", next_pc_o, 1);
        chk("R1", "halt", halt_o, 0);

        // Sweep: consumer op x src fields x producer op x load destination
        for (int n = 0; n < 32768; n++) begin
            int cop, ca, cb, pop, pd, xop, wop;
            bit eq, lu, tk;
            int epc, etgt, exp_next, exp_sel;
            cop = n & 7; ca = (n >> 3) & 7; cb = (n >> 6) & 7;
            pop = (n >> 9) & 7; pd = (n >> 12) & 7;
            xop = ((n >> 3) ^ (n >> 9) ^ n) & 7;
            eq  = ((n >> 1) ^ (n >> 7)) & 1;
            wop = (n >> 5) & 7;
            if (wop == 6) wop = 7;
            epc  = (n * 37) & 16'hffff;
            etgt = (n * 101 + 5) & 16'hffff;
            @(negedge clk);
            ifid_ctl = {3'(cop), 3'(ca), 3'(cb)};
            idex_op = 3'(pop); idex_dst = 3'(pd);
            exmem_op = 3'(xop); br_eq_i = eq; memwb_op = 3'(wop);
            pc_i = PC_W'(epc); br_target_i = PC_W'(etgt);
            #2;
            lu = (pop == 2) && ((uses_first(cop) && ca == pd) || (uses_second(cop) && cb == pd));
            tk = (xop == 4) && eq;
            exp_sel  = tk ? 2 : (lu ? 1 : 0);
            exp_next = tk ? etgt : (lu ? epc : ((epc + 1) & 16'hffff));
            // R2 R3 R8: stall only on a real load-use pairing, and not under a taken branch
            chk(tk ? "R8" : (lu ? "R2" : "R3"), "stall", stall_o, lu && !tk);
            // R4 R6: bubble into decode/execute on stall or squash
            chk(tk ? "R6" : "R4", "kill_idex", kill_idex_o, lu || tk);
            // R6 R7: younger squash only on a taken beq
            chk(tk ? "R6" : "R7", "kill_ifid", kill_ifid_o, tk);
            chk(tk ? "R6" : "R7", "kill_exmem", kill_exmem_o, tk);
            // R4 R5 R6: PC choice
            chk(tk ? "R6" : (lu ? "R4" : "R5"), "pc_sel", pc_sel_o, exp_sel);
            chk(tk ? "R6" : (lu ? "R4" : "R5"), "next_pc", next_pc_o, exp_next);
            // R9: no halt from non-halt write-back opcodes, even with halt earlier
            chk("R9", "halt_early", halt_o, 0);
        end

        // R5: PC wraps at its width
        @(negedge clk);
        ifid_ctl = 9'h1c0; idex_op = 3'd7; exmem_op = 3'd7; memwb_op = 3'd7;
        pc_i = '1;
        #2;
        chk("R5", "next_pc_wrap", next_pc_o, 0);

        // R9: halt rises with halt in write-back, then holds
        @(negedge clk);
        memwb_op = 3'd6;
        #2;
        chk("R9", "halt_rise", halt_o, 1);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            memwb_op = 3'd7;
            #2;
            chk("R9", "halt_hold", halt_o, 1);
        end
        // R1 R9: reset clears the halt
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #2;
        chk("R1", "halt_after_reset", halt_o, 0);

        @(negedge clk);
        finish_run();
    end
endmodule